// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external bus host read and write an internal 16-bit register space over a two-wire serial bus on which it only ever acts as a slave. It watches the clock and data lines through a synchronizer running on the system clock. It recognises START and STOP conditions and answers only to its own 7-bit device address. It never drives the clock line, and it pulls the data line low through a single output-enable.

A write transaction carries the address byte, a 16-bit register pointer sent as two bytes with the high byte first, and then any number of data bytes. Each data byte lands in the next register in turn. To read, the host first sets the pointer with a write, ends that transfer with STOP, and then opens a new transfer with the read bit set. Bytes then stream out from consecutive registers until the host declines one. Toward internal logic the block presents a plain parallel register port: a one-cycle write strobe and a one-cycle read strobe, both qualified by the pointer.

Top module: `twi_regport`

## Requirements
- R1: While reset is held and in the first cycles after it, `sda_oe`, `reg_we` and `reg_re` are all 0.
- R2: Clock and data activity that does not begin with a START (data falling while clock is high) is ignored: no acknowledge is driven and no register strobe occurs.
- R3: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. Bit 0 of that byte selects the direction: 0 means write and 1 means read. The block holds `sda_oe` high from the clock fall that ends the eighth bit until the clock fall that ends the ninth.
- R4: An address byte that does not match gets no acknowledge. Later bytes are then also ignored, with no acknowledge and no strobe, until the next START.
- R5: In a write transfer, the two bytes after the address byte load the register pointer, high byte first. Both bytes are acknowledged.
- R6: Each later write byte produces a single-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. After that the pointer increases by one, and 0xFFFF wraps to 0x0000. `reg_we` and `reg_re` are never high together.
- R7: In a read transfer, each byte is fetched with a single-cycle `reg_re`. `reg_rdata` is taken in that same cycle from the register at `reg_addr`, and the pointer advances by one after each byte. The byte is sent most significant bit first. `sda_oe` changes only while the clock is low.
- R8: During a read, an acknowledge from the host (data low on the ninth clock) starts the next byte. A non-acknowledge ends the burst: no further `reg_re` occurs, and `sda_oe` stays 0 until STOP.
- R9: A repeated START whose address byte reverses the direction of the transfer already in progress gets no acknowledge. A repeated START that keeps the same direction is accepted.
- R10: A STOP returns the block to idle with `sda_oe` at 0. It also clears the direction lock, so the next transfer may use either direction.
- R11: Each input line passes through `SYNC_STAGES` flops plus one edge-detect flop. With the default of 2 stages, the acknowledge drive appears in the third system-clock cycle after the clock line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 16 | Register pointer presented to internal logic |
| reg_wdata | output | 8 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_re | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, sampled in the `reg_re` cycle |

## Verification
Every reaction of the block is tied to an edge of the serial clock seen through the synchronizer. A clock fall reaches the state register three system clocks after the bench moves the line. So the acknowledge is checked as still absent two cycles after the fall and present on the third, and the host samples data only in the middle of each high phase, well after the slave has settled. Register strobes happen in the cycle the state register reacts to the fall that ends a byte. A per-cycle model in the bench pops an expected address and datum from its queue each time a strobe shows up, so any strobe that is early, extra or missing is reported at once.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } twi_state_e;

  typedef enum logic [1:0] {
    B_DEV,
    B_PHI,
    B_PLO,
    B_DAT
  } twi_byte_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_now,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign sda_now   = sda_p[STAGES-1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re
);
  twi_state_e        st_q, st_n;
  twi_byte_e         role_q, role_n;
  logic [3:0]        bit_q, bit_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              rw_q, rw_n;
  logic              lock_q, lock_n;
  logic              ldir_q, ldir_n;
  logic              mack_q, mack_n;
  logic              we_c, re_c;

  always_comb begin
    st_n   = st_q;
    role_n = role_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    ptr_n  = ptr_q;
    rw_n   = rw_q;
    lock_n = lock_q;
    ldir_n = ldir_q;
    mack_n = mack_q;
    we_c   = 1'b0;
    re_c   = 1'b0;
    if (stop_det) begin
      st_n   = S_IDLE;
      lock_n = 1'b0;
    end else if (start_det) begin
      st_n   = S_RX;
      role_n = B_DEV;
      bit_n  = 4'd0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_n = S_ACK;
            unique case (role_q)
              B_DEV: begin
                if (sh_q[7:1] == DEV_ADDR && !(lock_q && sh_q[0] != ldir_q)) begin
                  rw_n   = sh_q[0];
                  lock_n = 1'b1;
                  ldir_n = sh_q[0];
                  role_n = sh_q[0] ? B_DAT : B_PHI;
                end else begin
                  st_n = S_IDLE;
                end
              end
              B_PHI: begin
                ptr_n[PTR_W-1:BYTE_W] = sh_q;
                role_n = B_PLO;
              end
              B_PLO: begin
                ptr_n[BYTE_W-1:0] = sh_q;
                role_n = B_DAT;
              end
              default: begin
                we_c  = 1'b1;
                ptr_n = ptr_q + 1'b1;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bit_n = 4'd0;
            if (rw_q) begin
              re_c = 1'b1;
              sh_n = reg_rdata;
              st_n = S_TX;
            end else begin
              st_n = S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_n  = S_MACK;
              ptr_n = ptr_q + 1'b1;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              bit_n = bit_q + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              re_c  = 1'b1;
              sh_n  = reg_rdata;
              bit_n = 4'd0;
              st_n  = S_TX;
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_n_reg_reset();
    end else begin
      st_q   <= st_n;
      role_q <= role_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      rw_q   <= rw_n;
      lock_q <= lock_n;
      ldir_q <= ldir_n;
      mack_q <= mack_n;
    end
  end

  task automatic st_n_reg_reset();
    st_q   <= S_IDLE;
    role_q <= B_DEV;
    bit_q  <= 4'd0;
    sh_q   <= '0;
    ptr_q  <= '0;
    rw_q   <= 1'b0;
    lock_q <= 1'b0;
    ldir_q <= 1'b0;
    mack_q <= 1'b0;
  endtask

  assign sda_oe    = (st_q == S_ACK) | ((st_q == S_TX) & ~sh_q[BYTE_W-1]);
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = we_c;
  assign reg_re    = re_c;
endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic rst_meta, rst_q;
  logic scl_s, sda_s, scl_rise, scl_fall, sta, sto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q),
    .scl_in    (scl_i),
    .sda_in    (sda_i),
    .scl_now   (scl_s),
    .sda_now   (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (sta),
    .stop_det  (sto)
  );

  twi_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (sta),
    .stop_det  (sto),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re)
  );
endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        stop_det,
  input logic        sda_oe,
  input logic        reg_we,
  input logic        reg_re,
  input logic [15:0] reg_addr
);
  // R10: a STOP leaves the data line released
  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R7: the drive changes only while the clock is low
  assert_oe_steady_scl_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R6: strobes never overlap
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R6: pointer steps by one after a write
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 1'b1);

  // R7: fetches happen in the low phase
  assert_fetch_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> !scl_s);
endmodule

bind twi_regport twi_regport_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .scl_s    (scl_s),
  .stop_det (sto),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_addr (reg_addr)
);

// File: tb/twi_regport_test.sv
module twi_regport_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe, reg_we, reg_re;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [7:0]  mem [0:255];
  wire         sda_line = sda_m & ~sda_oe;
  int          errors = 0;
  int          checks = 0;
  logic [23:0] wq[$];
  logic [15:0] rq[$];

  always #4 clk = ~clk;

  twi_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr[7:0]];
  always @(posedge clk) if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle reference: every strobe must match the next expected access
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wq.size() == 0) chk(0, "R6 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [23:0] e;
          e = wq.pop_front();
          chk({reg_addr, reg_wdata} == e, "R6 write access", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_re) begin
        if (rq.size() == 0) chk(0, "R8 unexpected fetch", reg_addr, 0);
        else begin
          logic [15:0] e;
          e = rq.pop_front();
          chk(reg_addr == e, "R7 fetch address", reg_addr, e);
        end
      end
      if (reg_we && reg_re) chk(0, "R6 overlapping strobes", 1, 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    wait_n(5); sda_m = b;
    wait_n(5); scl_m = 1'b1;
    wait_n(5); r = sda_line;
    wait_n(5); scl_m = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_n(5);
    scl_m = 1'b1; wait_n(10);
    sda_m = 1'b0; wait_n(10);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    wait_n(5); sda_m = 1'b0;
    wait_n(5); scl_m = 1'b1;
    wait_n(10); sda_m = 1'b1;
    wait_n(10);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string tag);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    wait_n(2);
    chk(sda_oe == 1'b0, "R11 ack not before third cycle", sda_oe, 0);
    wait_n(1);
    chk(sda_oe == exp_ack, {tag, " ack drive on third cycle R11"}, sda_oe, exp_ack);
    bit_xfer(1'b1, r);
    chk(~r == exp_ack, {tag, " ack"}, ~r, exp_ack);
  endtask

  task automatic recv_byte(input logic host_ack, input logic [7:0] exp, input string tag);
    logic r;
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      d[i] = r;
    end
    bit_xfer(~host_ack, r);
    chk(d == exp, tag, d, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wait_n(3);
    chk(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 reset outputs", {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    wait_n(5);
    chk(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 after reset", {sda_oe, reg_we, reg_re}, 0);
    scl_m = 1'b0; wait_n(5);

    // R2: a matching byte without START is ignored
    send_byte(8'h74, 1'b0, "R2");
    scl_m = 1'b1; wait_n(10);

    // R3 R5 R6: write burst at 0x1234
    start_c();
    send_byte(8'h74, 1'b1, "R3");
    send_byte(8'h12, 1'b1, "R5");
    send_byte(8'h34, 1'b1, "R5");
    wq.push_back({16'h1234, 8'hA5}); send_byte(8'hA5, 1'b1, "R6");
    wq.push_back({16'h1235, 8'h3C}); send_byte(8'h3C, 1'b1, "R6");
    wq.push_back({16'h1236, 8'hFF}); send_byte(8'hFF, 1'b1, "R6");
    stop_c();
    chk(sda_oe == 0, "R10 released after stop", sda_oe, 0);

    // R6: pointer wrap
    start_c();
    send_byte(8'h74, 1'b1, "R3");
    send_byte(8'hFF, 1'b1, "R5");
    send_byte(8'hFF, 1'b1, "R5");
    wq.push_back({16'hFFFF, 8'h11}); send_byte(8'h11, 1'b1, "R6 wrap");
    wq.push_back({16'h0000, 8'h22}); send_byte(8'h22, 1'b1, "R6 wrap");
    stop_c();

    // R7 R8: read burst from 0x1234
    start_c();
    send_byte(8'h74, 1'b1, "R3"); send_byte(8'h12, 1'b1, "R5"); send_byte(8'h34, 1'b1, "R5");
    stop_c();
    rq.push_back(16'h1234); rq.push_back(16'h1235); rq.push_back(16'h1236);
    start_c();
    send_byte(8'h75, 1'b1, "R3 read");
    recv_byte(1'b1, 8'hA5, "R7 read byte 0");
    recv_byte(1'b1, 8'h3C, "R7 read byte 1");
    recv_byte(1'b0, 8'hFF, "R8 last byte");
    wait_n(6);
    chk(sda_oe == 0, "R8 released after nack", sda_oe, 0);
    stop_c();

    // R6 R7: read across the wrap
    start_c();
    send_byte(8'h74, 1'b1, "R3"); send_byte(8'hFF, 1'b1, "R5"); send_byte(8'hFF, 1'b1, "R5");
    stop_c();
    rq.push_back(16'hFFFF); rq.push_back(16'h0000);
    start_c();
    send_byte(8'h75, 1'b1, "R3 read");
    recv_byte(1'b1, 8'h11, "R7 wrap read 0");
    recv_byte(1'b0, 8'h22, "R6 wrap read 1");
    stop_c();

    // R4: wrong address, then data is ignored
    start_c();
    send_byte(8'h44, 1'b0, "R4 address");
    send_byte(8'h12, 1'b0, "R4 data");
    stop_c();

    // R9: direction reversal on repeated START
    start_c();
    send_byte(8'h74, 1'b1, "R3"); send_byte(8'h00, 1'b1, "R5"); send_byte(8'h10, 1'b1, "R5");
    start_c();
    send_byte(8'h75, 1'b0, "R9 reversed");
    stop_c();

    // R9: same direction repeated START accepted
    start_c();
    send_byte(8'h74, 1'b1, "R3"); send_byte(8'h00, 1'b1, "R5"); send_byte(8'h10, 1'b1, "R5");
    wq.push_back({16'h0010, 8'h77}); send_byte(8'h77, 1'b1, "R6");
    start_c();
    send_byte(8'h74, 1'b1, "R9 same direction");
    send_byte(8'h00, 1'b1, "R5"); send_byte(8'h20, 1'b1, "R5");
    wq.push_back({16'h0020, 8'h88}); send_byte(8'h88, 1'b1, "R9 write after restart");
    stop_c();

    // R10: STOP clears the lock, read now allowed
    start_c();
    send_byte(8'h74, 1'b1, "R3"); send_byte(8'h00, 1'b1, "R5"); send_byte(8'h10, 1'b1, "R5");
    stop_c();
    rq.push_back(16'h0010);
    start_c();
    send_byte(8'h75, 1'b1, "R10 read after stop");
    recv_byte(1'b0, 8'h77, "R10 read data");
    stop_c();

    wait_n(10);
    chk(wq.size() == 0, "R6 all writes seen", wq.size(), 0);
    chk(rq.size() == 0, "R7 all fetches seen", rq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule